// File: doc/BRIEF.md
# Burst Initiator for a Multiplexed Address/Data Bus

This block is the initiating side of a shared bus on which address and data take turns on one 32-bit set of lines. A local requester first loads data words into a small queue inside the block. It then pulses a start strobe together with a start address and a 4-bit bus command. The block raises its bus request and waits for the arbiter's grant. In the first clock after grant is sampled high, it drives the address and the command. In each later clock it drives one queued word, with every byte enabled.

The burst ends when the queue runs out. A tenure timer can also end it early. The timer is loaded from a tenure limit input when grant is sampled and counts down once per bus clock. When it runs out, the block gives the bus back even if words are still queued. In both cases a one-clock done pulse reports how many words were moved, whether the burst was cut short, and the address at which the requester should resume. Words that were not sent stay in the queue in their original order, so the next start sends them first.

Top module: `burst_initiator`

## Requirements
- R1: After reset, bus_req_o, ad_oe_o, addr_phase_o, data_phase_o, done_o and cut_short_o are 0, and words_o is 0.
- R2: A go_i pulse seen while idle with at least one queued word raises bus_req_o in the next clock. A go_i pulse seen with an empty queue is ignored: bus_req_o stays 0.
- R3: The block does not drive the lines (ad_oe_o=0) until bus_gnt_i has been sampled high while requesting. The clock after that grant edge is the address clock, in which ad_oe_o=1, addr_phase_o=1, ad_o equals the latched start address and cbe_o equals the latched 4-bit command (for example 0110 memory read, 0111 memory write, 1110 cache-line read).
- R4: Every clock after the address clock is a data clock (data_phase_o=1) that moves exactly one queued word on ad_o, in queue order, with cbe_o=1111.
- R5: Once the last queued word has been moved, the next clock has done_o=1 for one clock with bus_req_o=0, and ad_oe_o=0, cut_short_o=0 and words_o equal to the number of words moved.
- R6: The tenure timer is loaded at the grant edge with the value L taken from tenure_i, where 0 means 256. The bus is then driven for at most L clocks, the address clock included, so at most L-1 words are moved.
- R7: When the timer ends a burst with words still queued, done_o pulses with cut_short_o=1. words_o holds the count moved and resume_addr_o equals the start address plus 4 times words_o. The unsent words remain queued in order. With L=1 no word is moved.
- R8: A push is ignored while a transaction is in progress (from the accepted go_i until the done clock) and when the 16-entry queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Write push_data_i into the queue |
| push_data_i | input | 32 | Data word to queue |
| go_i | input | 1 | Start strobe from the local requester |
| addr_i | input | 32 | Start address, latched on an accepted go_i |
| cmd_i | input | 4 | Bus command, latched on an accepted go_i |
| tenure_i | input | 8 | Tenure limit in clocks, 0 meaning 256 |
| bus_gnt_i | input | 1 | Grant from the arbiter |
| bus_req_o | output | 1 | Request to the arbiter |
| ad_o | output | 32 | Multiplexed address/data lines |
| ad_oe_o | output | 1 | High while the block owns the lines |
| cbe_o | output | 4 | Command in the address clock, byte enables in data clocks |
| addr_phase_o | output | 1 | Address clock marker |
| data_phase_o | output | 1 | Data clock marker |
| done_o | output | 1 | One-clock end-of-burst pulse |
| cut_short_o | output | 1 | Last burst ended by the timer with words still queued |
| words_o | output | 8 | Words moved in the last burst |
| resume_addr_o | output | 32 | Start address plus 4 times words_o |

## Verification
Directed cases cover an idle start with an empty queue, a full queue with the 256-clock limit, which tells a clean drain apart from a timer cut, and limits of 1 and 3, which test the edge of the timer window and the resume address. A follow-up burst sends the leftover words, which shows that an early cut keeps the queue order intact. Random bursts vary the queue depth, the limit, the grant delay and the command, so that queue-empty and timer endings occur in both orders. Words pushed during a burst and pushes into a full queue are checked by observing that those words never appear in later data clocks.

// File: rtl/bi_pkg.sv
package bi_pkg;
  localparam int unsigned BI_DATA_W = 32;
  localparam int unsigned BI_CMD_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_ADDR = 3'd2,
    ST_DATA = 3'd3,
    ST_DONE = 3'd4
  } bi_state_e;
endpackage

// File: rtl/bi_fifo.sv
module bi_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             last
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             full, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign last    = (cnt_q == CW'(1));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = wp_q + AW'(1);
    if (do_pop)  rp_d = rp_q + AW'(1);
    if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  // R8: occupancy never exceeds the queue depth
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R4: a data clock never pops an empty queue
  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/bi_tenure_timer.sv
module bi_tenure_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expire
);
  localparam int unsigned CW = W + 1;

  logic [CW-1:0] cnt_q, cnt_d, load_val;

  assign load_val = (limit == '0) ? {1'b1, {W{1'b0}}} : CW'(limit);
  assign expire   = (cnt_q == CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load)                    cnt_d = load_val;
    else if (run && cnt_q != '0) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6: the tenure count is never run below zero
  p_timer_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |-> cnt_q != '0);
endmodule

// File: rtl/bi_ctrl.sv
module bi_ctrl
  import bi_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             q_empty,
  input  logic             q_last,
  input  logic             gnt,
  input  logic             tmr_expire,
  output bi_state_e        state,
  output logic             accept,
  output logic             pop,
  output logic             tmr_load,
  output logic             tmr_run,
  output logic             cut,
  output logic [CNT_W-1:0] words
);
  bi_state_e        state_q, state_d;
  logic             cut_q, cut_d;
  logic [CNT_W-1:0] words_q, words_d;

  always_comb begin
    state_d  = state_q;
    cut_d    = cut_q;
    words_d  = words_q;
    accept   = 1'b0;
    pop      = 1'b0;
    tmr_load = 1'b0;
    tmr_run  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go && !q_empty) begin
          accept  = 1'b1;
          cut_d   = 1'b0;
          words_d = '0;
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        if (gnt) begin
          tmr_load = 1'b1;
          state_d  = ST_ADDR;
        end
      end
      ST_ADDR: begin
        tmr_run = 1'b1;
        if (tmr_expire) begin
          cut_d   = 1'b1;
          state_d = ST_DONE;
        end else begin
          state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        tmr_run = 1'b1;
        pop     = 1'b1;
        words_d = words_q + CNT_W'(1);
        if (q_last) begin
          state_d = ST_DONE;
        end else if (tmr_expire) begin
          cut_d   = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cut_q   <= 1'b0;
      words_q <= '0;
    end else begin
      state_q <= state_d;
      cut_q   <= cut_d;
      words_q <= words_d;
    end
  end

  assign state = state_q;
  assign cut   = cut_q;
  assign words = words_q;

  // R5: the done state lasts one clock and returns to idle
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));

  // R3: the address clock is entered only from a granted request
  p_addr_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR) |-> ($past(state_q) == ST_REQ && $past(gnt)));
endmodule

// File: rtl/burst_initiator.sv
module burst_initiator
  import bi_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned TIMER_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_i,
  input  logic [31:0]         push_data_i,
  input  logic                go_i,
  input  logic [31:0]         addr_i,
  input  logic [3:0]          cmd_i,
  input  logic [TIMER_W-1:0]  tenure_i,
  input  logic                bus_gnt_i,
  output logic                bus_req_o,
  output logic [31:0]         ad_o,
  output logic                ad_oe_o,
  output logic [3:0]          cbe_o,
  output logic                addr_phase_o,
  output logic                data_phase_o,
  output logic                done_o,
  output logic                cut_short_o,
  output logic [TIMER_W-1:0]  words_o,
  output logic [31:0]         resume_addr_o
);
  localparam int unsigned HW = TIMER_W + 1;

  bi_state_e            state;
  logic                 accept, pop, tmr_load, tmr_run, tmr_expire;
  logic                 q_empty, q_last, q_push;
  logic [31:0]          q_head;
  logic [31:0]          base_q, base_d;
  logic [3:0]           cmd_q, cmd_d;
  logic                 cut;
  logic [TIMER_W-1:0]   words;

  assign q_push = push_i && (state == ST_IDLE);

  bi_fifo #(.WIDTH(BI_DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .wdata (push_data_i),
    .pop   (pop),
    .head  (q_head),
    .empty (q_empty),
    .last  (q_last)
  );

  bi_tenure_timer #(.W(TIMER_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .run    (tmr_run),
    .limit  (tenure_i),
    .expire (tmr_expire)
  );

  bi_ctrl #(.CNT_W(TIMER_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go_i),
    .q_empty    (q_empty),
    .q_last     (q_last),
    .gnt        (bus_gnt_i),
    .tmr_expire (tmr_expire),
    .state      (state),
    .accept     (accept),
    .pop        (pop),
    .tmr_load   (tmr_load),
    .tmr_run    (tmr_run),
    .cut        (cut),
    .words      (words)
  );

  always_comb begin
    base_d = base_q;
    cmd_d  = cmd_q;
    if (accept) begin
      base_d = addr_i;
      cmd_d  = cmd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cmd_q  <= '0;
    end else begin
      base_q <= base_d;
      cmd_q  <= cmd_d;
    end
  end

  always_comb begin
    ad_o  = '0;
    cbe_o = '0;
    if (state == ST_ADDR) begin
      ad_o  = base_q;
      cbe_o = cmd_q;
    end else if (state == ST_DATA) begin
      ad_o  = q_head;
      cbe_o = '1;
    end
  end

  assign addr_phase_o  = (state == ST_ADDR);
  assign data_phase_o  = (state == ST_DATA);
  assign ad_oe_o       = addr_phase_o || data_phase_o;
  assign bus_req_o     = (state == ST_REQ) || ad_oe_o;
  assign done_o        = (state == ST_DONE);
  assign cut_short_o   = cut;
  assign words_o       = words;
  assign resume_addr_o = base_q + {22'd0, words, 2'b00};

  // Tenure length seen on the lines, used only by the R6 property.
  logic [HW-1:0] held_q, held_d, lim_eff;
  assign lim_eff = (tenure_i == '0) ? {1'b1, {TIMER_W{1'b0}}} : HW'(tenure_i);
  always_comb held_d = ad_oe_o ? held_q + HW'(1) : '0;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  // R6: the lines are held for at most the loaded tenure
  p_tenure_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe_o |-> (held_q < lim_eff));

  // R3: the lines are first driven right after a sampled grant
  p_oe_needs_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe_o) |-> $past(bus_gnt_i));

  // R5: request is down whenever done is reported
  p_req_low_at_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!bus_req_o && !ad_oe_o));

  // R5: done is a single-clock pulse
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: tb/burst_initiator_tb.sv
module burst_initiator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QDEPTH     = 16;

  logic        clk, rst_n;
  logic        push_i, go_i, bus_gnt_i;
  logic [31:0] push_data_i, addr_i;
  logic [3:0]  cmd_i;
  logic [7:0]  tenure_i;
  logic        bus_req_o, ad_oe_o, addr_phase_o, data_phase_o, done_o, cut_short_o;
  logic [31:0] ad_o, resume_addr_o;
  logic [3:0]  cbe_o;
  logic [7:0]  words_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] mq[$];

  burst_initiator u_dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
    .go_i(go_i), .addr_i(addr_i), .cmd_i(cmd_i), .tenure_i(tenure_i),
    .bus_gnt_i(bus_gnt_i), .bus_req_o(bus_req_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .cbe_o(cbe_o), .addr_phase_o(addr_phase_o), .data_phase_o(data_phase_o),
    .done_o(done_o), .cut_short_o(cut_short_o), .words_o(words_o),
    .resume_addr_o(resume_addr_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int eff_limit(input logic [7:0] l);
    return (l == 8'd0) ? 256 : int'(l);
  endfunction

  function automatic int exp_words(input int queued, input logic [7:0] l);
    int cap;
    cap = eff_limit(l) - 1;
    return (queued < cap) ? queued : cap;
  endfunction

  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      push_i      = 1'b1;
      push_data_i = $urandom();
      if (mq.size() < QDEPTH) mq.push_back(push_data_i);
    end
    @(negedge clk);
    push_i = 1'b0;
  endtask

  task automatic burst(input logic [7:0] lim, input int gdelay,
                       input logic [3:0] c, input logic [31:0] a);
    int  queued, ew, moved, oe_cycles, cyc;
    bit  seen_done, injected;
    queued = mq.size();
    ew     = exp_words(queued, lim);
    @(negedge clk);
    tenure_i = lim; cmd_i = c; addr_i = a; go_i = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
    if (queued == 0) begin
      for (int i = 0; i < 4; i++) begin
        chk(bus_req_o == 1'b0, "R2", "req after go with empty queue", 32'(bus_req_o), 32'd0);
        @(negedge clk);
      end
      return;
    end
    chk(bus_req_o == 1'b1, "R2", "req after accepted go", 32'(bus_req_o), 32'd1);
    for (int i = 0; i < gdelay; i++) begin
      chk(ad_oe_o == 1'b0, "R3", "lines driven before grant", 32'(ad_oe_o), 32'd0);
      @(negedge clk);
    end
    bus_gnt_i = 1'b1;
    @(negedge clk);
    bus_gnt_i = 1'b0;
    chk(addr_phase_o == 1'b1 && ad_oe_o == 1'b1, "R3", "address clock after grant",
        32'(addr_phase_o), 32'd1);
    chk(ad_o == a, "R3", "address on lines", ad_o, a);
    chk(cbe_o == c, "R3", "command field", 32'(cbe_o), 32'(c));
    moved = 0; oe_cycles = 1; seen_done = 0; injected = 0; cyc = 0;
    while (!seen_done && cyc < 400) begin
      @(negedge clk);
      cyc++;
      push_i = 1'b0;
      if (data_phase_o) begin
        oe_cycles++;
        chk(cbe_o == 4'hF, "R4", "byte enables in data clock", 32'(cbe_o), 32'hF);
        chk(ad_o == mq[0], "R4", "data word order", ad_o, mq[0]);
        void'(mq.pop_front());
        moved++;
        if (!injected) begin
          injected    = 1;
          push_i      = 1'b1;
          push_data_i = 32'hDEAD_BEEF;
        end
      end else if (done_o) begin
        seen_done = 1;
        chk(bus_req_o == 1'b0 && ad_oe_o == 1'b0, "R5", "request dropped at done",
            32'(bus_req_o), 32'd0);
        chk(words_o == 8'(ew), "R5", "word count", 32'(words_o), 32'(ew));
        chk(moved == ew, "R6", "words seen on bus", 32'(moved), 32'(ew));
        chk(oe_cycles <= eff_limit(lim), "R6", "tenure length",
            32'(oe_cycles), 32'(eff_limit(lim)));
        chk(cut_short_o == (queued > ew), "R7", "cut flag",
            32'(cut_short_o), 32'(queued > ew));
        chk(resume_addr_o == a + 32'(4 * ew), "R7", "resume address",
            resume_addr_o, a + 32'(4 * ew));
      end else begin
        chk(1'b0, "R5", "done missing after last bus clock", 32'(ad_oe_o), 32'd0);
        seen_done = 1;
      end
    end
    push_i = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0, "R5", "done lasts one clock", 32'(done_o), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] cmds [3];
    void'($urandom(32'd1357));
    cmds[0] = 4'b0110; cmds[1] = 4'b0111; cmds[2] = 4'b1110;
    rst_n = 1'b0; push_i = 1'b0; go_i = 1'b0; bus_gnt_i = 1'b0;
    push_data_i = '0; addr_i = '0; cmd_i = '0; tenure_i = '0;
    repeat (3) @(negedge clk);
    chk(bus_req_o == 0 && ad_oe_o == 0 && done_o == 0 && addr_phase_o == 0
        && data_phase_o == 0 && cut_short_o == 0, "R1", "outputs in reset",
        {26'd0, bus_req_o, ad_oe_o, done_o, addr_phase_o, data_phase_o, cut_short_o}, 32'd0);
    chk(words_o == 8'd0, "R1", "count in reset", 32'(words_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: start with an empty queue is ignored
    burst(8'd5, 0, 4'b0110, 32'h0000_1000);

    // R8: 18 pushes into a 16-entry queue, last two dropped; R6: limit 0 = 256
    push_words(18);
    burst(8'd0, 2, 4'b0111, 32'h1000_0000);

    // R7: limit 1 moves nothing, words stay queued
    push_words(5);
    burst(8'd1, 1, 4'b1110, 32'h2000_0040);
    // R7: limit 3 moves two of five, then the rest follow in order (R5)
    burst(8'd3, 0, 4'b0110, 32'h2000_0040);
    burst(8'd10, 3, 4'b0110, 32'h2000_0048);

    for (int k = 0; k < 24; k++) begin
      push_words(int'($urandom_range(0, 6)));
      burst(($urandom_range(0, 4) == 0) ? 8'd0 : 8'($urandom_range(1, 8)),
            int'($urandom_range(0, 3)), cmds[$urandom_range(0, 2)],
            {$urandom_range(0, 32'h3FFF_FFFF), 2'b00});
    end
    // drain whatever remains
    while (mq.size() > 0) burst(8'd0, 0, 4'b0111, 32'h3000_0000);
    burst(8'd4, 0, 4'b0111, 32'h3000_0100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule